// File: doc/BRIEF.md
# Lock-Protected Pad Configuration Bank

This block stores the pad and pin-function settings for one port of `PORT_W` pins: a peripheral-select bit, a pull-up and a pull-down enable, a digital-path enable and a one-of-three drive strength (2, 4 or 8 mA) for each pin. The settings leave the block as plain per-pin vectors for the pad ring. A simple word-indexed write/read port carries all accesses. Writes take effect on the next rising clock edge. Reads are combinational from the address.

The peripheral-select, pull-up, pull-down and digital-enable settings are guarded by a per-pin commit mask. A write changes only the pins whose mask bit is 1. The mask can be changed only while the bank is unlocked. Unlocking needs a 32-bit key written to the lock word. Any write to the mask word locks the bank again. The hardware keeps the pull settings free of conflict, and it keeps exactly one drive strength selected for each pin.

Top module: `padcfg_bank`

## Requirements
- R1: After reset the bank is locked, the commit mask equals the parameter `COMMIT_RESET`, every pin selects 2 mA, and all other settings are 0.
- R2: A write to index 0 unlocks the bank when the data equals `UNLOCK_KEY` (default 0x4C4F434B). A write of any other value to index 0 locks the bank.
- R3: A read of index 0 returns 1 while locked and 0 while unlocked, in bit 0. All other bits read 0.
- R4: A write to the commit mask (index 1) is ignored while the bank is locked. A write to index 1 leaves the bank locked whether or not it was accepted.
- R5: A write to peripheral select (index 2), pull-up (3), pull-down (4) or digital enable (5) updates only the pins whose commit bit is 1. The other pins keep their values.
- R6: A committed 1 written to a pin's pull-up clears that pin's pull-down, and a committed 1 written to a pin's pull-down clears its pull-up. Both are never set together.
- R7: Writing a 1 to a pin in a drive register (index 6 = 2 mA, 7 = 4 mA, 8 = 8 mA) selects that strength and clears the other two for that pin. The drive registers are not gated by the commit mask.
- R8: Writing a 0 that leaves a pin with no drive bit set selects 2 mA for that pin. Exactly one drive bit per pin is set at all times.
- R9: Each index 1 to 8 reads back its `PORT_W`-bit register, with the upper bits 0. Indices 9 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the addressed word |
| addr | input | 4 | Word index |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr` |
| altFuncOut | output | PORT_W | Per-pin peripheral select |
| pullUpOut | output | PORT_W | Per-pin pull-up enable |
| pullDownOut | output | PORT_W | Per-pin pull-down enable |
| digEnOut | output | PORT_W | Per-pin digital enable |
| drv2Out | output | PORT_W | Per-pin 2 mA select |
| drv4Out | output | PORT_W | Per-pin 4 mA select |
| drv8Out | output | PORT_W | Per-pin 8 mA select |

## Verification
The hardest state to reach is a partial commit mask. In it, some pins of one gated write take the new value and others keep the old one. Reaching it needs a key write, then a mask write, and each mask write locks the bank again. The bench builds the bank with a reset mask of 0xF0, so gating is visible from the first write. It then runs the unlock, mask-write and relock sequence in order, and afterwards writes key values and random data to random indices. A behavioural model follows every cycle.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_LOCK   = 4'd0,
    REG_COMMIT = 4'd1,
    REG_ALT    = 4'd2,
    REG_PULLUP = 4'd3,
    REG_PULLDN = 4'd4,
    REG_DIGEN  = 4'd5,
    REG_DRV2   = 4'd6,
    REG_DRV4   = 4'd7,
    REG_DRV8   = 4'd8
  } regIdx_e;

  typedef struct packed {
    logic wrCommit;
    logic wrAlt;
    logic wrPullUp;
    logic wrPullDn;
    logic wrDigEn;
    logic wrDrv2;
    logic wrDrv4;
    logic wrDrv8;
  } cfgStrobe_t;
endpackage

// File: rtl/padcfg_ctrl.sv
module padcfg_ctrl
  import padcfg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C4F434B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output cfgStrobe_t        strobe,
  output logic              isLocked
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isLocked <= 1'b1;
    end else if (wrEn) begin
      if (addr == REG_LOCK)        isLocked <= (wrData != UNLOCK_KEY);
      else if (addr == REG_COMMIT) isLocked <= 1'b1;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.wrCommit = wrEn && (addr == REG_COMMIT) && !isLocked;
    strobe.wrAlt    = wrEn && (addr == REG_ALT);
    strobe.wrPullUp = wrEn && (addr == REG_PULLUP);
    strobe.wrPullDn = wrEn && (addr == REG_PULLDN);
    strobe.wrDigEn  = wrEn && (addr == REG_DIGEN);
    strobe.wrDrv2   = wrEn && (addr == REG_DRV2);
    strobe.wrDrv4   = wrEn && (addr == REG_DRV4);
    strobe.wrDrv8   = wrEn && (addr == REG_DRV8);
  end

  // R2
  key_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_LOCK && wrData == UNLOCK_KEY) |=> !isLocked);
  // R2
  bad_key_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_LOCK && wrData != UNLOCK_KEY) |=> isLocked);
  // R4
  commit_relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_COMMIT) |=> isLocked);
endmodule

// File: rtl/padcfg_regs.sv
module padcfg_regs
  import padcfg_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int DATA_W = 32,
  parameter logic [PORT_W-1:0] COMMIT_RESET = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              isLocked,
  output logic [PORT_W-1:0] commitMask,
  output logic [PORT_W-1:0] altFunc,
  output logic [PORT_W-1:0] pullUp,
  output logic [PORT_W-1:0] pullDn,
  output logic [PORT_W-1:0] digEn,
  output logic [PORT_W-1:0] drv2,
  output logic [PORT_W-1:0] drv4,
  output logic [PORT_W-1:0] drv8,
  output logic [DATA_W-1:0] rdData
);
  localparam int PAD_W = DATA_W - PORT_W;

  logic [PORT_W-1:0] wrBits, gatedSet;
  logic [PORT_W-1:0] next4, next8;
  logic              anyDrvWr;

  assign wrBits   = wrData[PORT_W-1:0];
  assign gatedSet = wrBits & commitMask;

  function automatic logic [PORT_W-1:0] mergeGated(input logic [PORT_W-1:0] oldVal,
                                                   input logic [PORT_W-1:0] newVal,
                                                   input logic [PORT_W-1:0] mask);
    return (oldVal & ~mask) | (newVal & mask);
  endfunction

  // the 2 mA bit is always the complement of the other two, so only the
  // 4 and 8 mA next values need working out
  always_comb begin
    next4    = drv4;
    next8    = drv8;
    anyDrvWr = strobe.wrDrv2 | strobe.wrDrv4 | strobe.wrDrv8;
    if (strobe.wrDrv2) begin
      next4 = drv4 & ~wrBits;
      next8 = drv8 & ~wrBits;
    end else if (strobe.wrDrv4) begin
      next4 = wrBits;
      next8 = drv8 & ~wrBits;
    end else if (strobe.wrDrv8) begin
      next4 = drv4 & ~wrBits;
      next8 = wrBits;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitMask <= COMMIT_RESET;
      altFunc    <= '0;
      pullUp     <= '0;
      pullDn     <= '0;
      digEn      <= '0;
      drv2       <= '1;
      drv4       <= '0;
      drv8       <= '0;
    end else begin
      if (strobe.wrCommit) commitMask <= wrBits;
      if (strobe.wrAlt)    altFunc    <= mergeGated(altFunc, wrBits, commitMask);
      if (strobe.wrDigEn)  digEn      <= mergeGated(digEn, wrBits, commitMask);
      if (strobe.wrPullUp) begin
        pullUp <= mergeGated(pullUp, wrBits, commitMask);
        pullDn <= pullDn & ~gatedSet;
      end
      if (strobe.wrPullDn) begin
        pullDn <= mergeGated(pullDn, wrBits, commitMask);
        pullUp <= pullUp & ~gatedSet;
      end
      if (anyDrvWr) begin
        drv4 <= next4;
        drv8 <= next8;
        drv2 <= ~(next4 | next8);
      end
    end
  end

  always_comb begin
    case (addr)
      REG_LOCK:   rdData = {{(DATA_W-1){1'b0}}, isLocked};
      REG_COMMIT: rdData = {{PAD_W{1'b0}}, commitMask};
      REG_ALT:    rdData = {{PAD_W{1'b0}}, altFunc};
      REG_PULLUP: rdData = {{PAD_W{1'b0}}, pullUp};
      REG_PULLDN: rdData = {{PAD_W{1'b0}}, pullDn};
      REG_DIGEN:  rdData = {{PAD_W{1'b0}}, digEn};
      REG_DRV2:   rdData = {{PAD_W{1'b0}}, drv2};
      REG_DRV4:   rdData = {{PAD_W{1'b0}}, drv4};
      REG_DRV8:   rdData = {{PAD_W{1'b0}}, drv8};
      default:    rdData = '0;
    endcase
  end

  // R6
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pullUp & pullDn) == '0);

  for (genvar p = 0; p < PORT_W; p++) begin : g_pinChk
    // R8
    drv_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $countones({drv2[p], drv4[p], drv8[p]}) == 1);
  end
endmodule

// File: rtl/padcfg_bank.sv
module padcfg_bank
  import padcfg_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int DATA_W = 32,
  parameter logic [PORT_W-1:0] COMMIT_RESET = '1,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C4F434B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [PORT_W-1:0] altFuncOut,
  output logic [PORT_W-1:0] pullUpOut,
  output logic [PORT_W-1:0] pullDownOut,
  output logic [PORT_W-1:0] digEnOut,
  output logic [PORT_W-1:0] drv2Out,
  output logic [PORT_W-1:0] drv4Out,
  output logic [PORT_W-1:0] drv8Out
);
  cfgStrobe_t        strobe;
  logic              lockState;
  logic [PORT_W-1:0] commitMask;

  padcfg_ctrl #(.DATA_W(DATA_W), .UNLOCK_KEY(UNLOCK_KEY)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strobe(strobe), .isLocked(lockState)
  );

  padcfg_regs #(.PORT_W(PORT_W), .DATA_W(DATA_W), .COMMIT_RESET(COMMIT_RESET)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .wrData(wrData),
    .isLocked(lockState), .commitMask(commitMask),
    .altFunc(altFuncOut), .pullUp(pullUpOut), .pullDn(pullDownOut),
    .digEn(digEnOut), .drv2(drv2Out), .drv4(drv4Out), .drv8(drv8Out),
    .rdData(rdData)
  );

  // R4
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_COMMIT && lockState) |=> $stable(commitMask));
  // R5
  gated_alt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_ALT) |=>
      ((altFuncOut ^ $past(altFuncOut)) & ~$past(commitMask)) == '0);
  // R5
  gated_digen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == REG_DIGEN) |=>
      ((digEnOut ^ $past(digEnOut)) & ~$past(commitMask)) == '0);
endmodule

// File: tb/tb_padcfg_bank.sv
module tb_padcfg_bank;
  localparam int PW = 8;
  localparam int DW = 32;
  localparam logic [PW-1:0] CRST = 8'hF0;
  localparam logic [DW-1:0] KEY = 32'h4C4F434B;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [PW-1:0] altFuncOut, pullUpOut, pullDownOut, digEnOut, drv2Out, drv4Out, drv8Out;

  int compared = 0, mismatched = 0;
  bit running = 1'b0;

  // behavioural model state
  logic [PW-1:0] mCommit, mAlt, mPu, mPd, mDen;
  logic [PW-1:0] mDrv [3];
  bit mLocked;

  padcfg_bank #(.PORT_W(PW), .DATA_W(DW), .COMMIT_RESET(CRST), .UNLOCK_KEY(KEY)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .altFuncOut(altFuncOut), .pullUpOut(pullUpOut), .pullDownOut(pullDownOut),
    .digEnOut(digEnOut), .drv2Out(drv2Out), .drv4Out(drv4Out), .drv8Out(drv8Out)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      mLocked = 1'b1; mCommit = CRST;
      mAlt = '0; mPu = '0; mPd = '0; mDen = '0;
      mDrv[0] = '1; mDrv[1] = '0; mDrv[2] = '0;
    end else if (wrEn) begin
      if (addr == 0) mLocked = (wrData != KEY);
      else if (addr == 1) begin
        if (!mLocked) mCommit = wrData[PW-1:0];
        mLocked = 1'b1;
      end else if (addr >= 2 && addr <= 5) begin
        for (int i = 0; i < PW; i++) begin
          if (mCommit[i]) begin
            if (addr == 2) mAlt[i] = wrData[i];
            if (addr == 5) mDen[i] = wrData[i];
            if (addr == 3) begin mPu[i] = wrData[i]; if (wrData[i]) mPd[i] = 1'b0; end
            if (addr == 4) begin mPd[i] = wrData[i]; if (wrData[i]) mPu[i] = 1'b0; end
          end
        end
      end else if (addr >= 6 && addr <= 8) begin
        for (int i = 0; i < PW; i++) begin
          int sel;
          sel = int'(addr) - 6;
          if (wrData[i]) begin
            for (int k = 0; k < 3; k++) mDrv[k][i] = (k == sel);
          end else begin
            mDrv[sel][i] = 1'b0;
            if (!mDrv[0][i] && !mDrv[1][i] && !mDrv[2][i]) mDrv[0][i] = 1'b1;
          end
        end
      end
    end
  end

  function automatic logic [DW-1:0] expRd(input logic [3:0] a);
    case (a)
      4'd0: return {{(DW-1){1'b0}}, mLocked};
      4'd1: return {{(DW-PW){1'b0}}, mCommit};
      4'd2: return {{(DW-PW){1'b0}}, mAlt};
      4'd3: return {{(DW-PW){1'b0}}, mPu};
      4'd4: return {{(DW-PW){1'b0}}, mPd};
      4'd5: return {{(DW-PW){1'b0}}, mDen};
      4'd6: return {{(DW-PW){1'b0}}, mDrv[0]};
      4'd7: return {{(DW-PW){1'b0}}, mDrv[1]};
      4'd8: return {{(DW-PW){1'b0}}, mDrv[2]};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    if (rstN && running) begin
      check("R5 altFunc", {24'b0, altFuncOut}, {24'b0, mAlt});
      check("R5 digEn", {24'b0, digEnOut}, {24'b0, mDen});
      check("R6 pullUp", {24'b0, pullUpOut}, {24'b0, mPu});
      check("R6 pullDown", {24'b0, pullDownOut}, {24'b0, mPd});
      check("R7 drv2", {24'b0, drv2Out}, {24'b0, mDrv[0]});
      check("R7 drv4", {24'b0, drv4Out}, {24'b0, mDrv[1]});
      check("R8 drv8", {24'b0, drv8Out}, {24'b0, mDrv[2]});
      check("R9 rdData", rdData, expRd(addr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); wrEn = 1'b0; addr = a;
    #1 check(tag, rdData, exp);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got hang expected finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1; running = 1'b1;
    // R1 reset state
    rd(0, 1, "R1 locked after reset");
    rd(1, CRST, "R1 commit reset value");
    rd(6, 8'hFF, "R1 all pins 2 mA");
    rd(2, 0, "R1 altFunc zero");
    check("R1 pullUp zero", {24'b0, pullUpOut}, 0);
    // R5 gating with partial reset mask
    wr(2, 32'hFF);  rd(2, 8'hF0, "R5 partial commit on altFunc");
    // R6 pull exclusion
    wr(3, 32'hFF);  wr(4, 32'h3C);
    rd(3, 8'hC0, "R6 pull-down clears pull-up");
    rd(4, 8'h30, "R6 pull-down committed bits");
    // R4 locked commit write ignored
    wr(1, 32'h0F);  rd(1, CRST, "R4 commit ignored while locked");
    // R2 wrong key, then right key; R3 read value
    wr(0, 32'h12345678); rd(0, 1, "R2 wrong key stays locked");
    wr(0, KEY);          rd(0, 0, "R3 unlocked reads 0");
    wr(1, 32'h0F);  rd(1, 8'h0F, "R4 commit accepted when unlocked");
    rd(0, 1, "R4 commit write relocks");
    wr(1, 32'hFF);  rd(1, 8'h0F, "R4 commit ignored after relock");
    wr(2, 32'h55);  rd(2, 8'hF5, "R5 new mask gates altFunc");
    wr(5, 32'hFF);  rd(5, 8'h0F, "R5 digEn gated");
    wr(0, KEY); wr(0, KEY + 1); rd(0, 1, "R2 other value relocks");
    // R7 / R8 drive exclusivity
    wr(8, 32'h0F);  rd(8, 8'h0F, "R7 8 mA set");   rd(6, 8'hF0, "R7 2 mA cleared");
    wr(7, 32'h3C);  rd(7, 8'h3C, "R7 4 mA set");   rd(8, 8'h03, "R7 8 mA cleared");
    rd(6, 8'hC0, "R7 2 mA after 4 mA write");
    wr(7, 32'h00);  rd(7, 0, "R8 4 mA cleared");   rd(6, 8'hFC, "R8 fallback to 2 mA");
    wr(6, 32'h00);  rd(6, 8'hFC, "R8 clearing 2 mA keeps it");
    rd(8, 8'h03, "R8 8 mA untouched");
    // R9 unused indices
    rd(15, 0, "R9 unused index reads 0");
    wr(12, 32'hFFFFFFFF); rd(2, 8'hF5, "R9 unused write no effect");
    // random traffic, checked by the per-cycle model compare
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      wrEn   = ($urandom % 3) != 0;
      addr   = 4'($urandom % 12);
      wrData = (($urandom % 4) == 0) ? KEY : $urandom;
      if (addr == 0 && ($urandom % 2) == 0) wrData = KEY;
    end
    @(negedge clk); wrEn = 1'b0;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule